// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block turns a group of wired interrupt inputs into posted write messages aimed at a processor. Each input line has its own redirection entry, made of two 32-bit words. The entry sets whether the line is masked, which polarity counts as asserted, whether the line is edge or level triggered, the 8-bit vector carried as message data, and the destination ID and extended ID that form the target address. When a line fires, the block queues one message. A fixed-priority arbiter passes queued messages, one at a time, to a request/acknowledge write port.

Software reaches every internal register through two bus offsets. A write to the select offset picks an internal index. An access to the window offset then reads or writes the register at that index. A read placed right after a write returns the new contents, so software can use it to flush the write. A third offset takes end-of-interrupt (EOI) writes. An EOI re-arms a level-triggered line whose vector matches the written data. If that line is still asserted, its message is sent again.

Top module: `irq_msg_redirect`

## Requirements
- R1: After reset, the select register reads 0 and every low entry word reads 0x0001_0000 (masked, all other fields zero). Every high word reads 0, and msg_req is low.
- R2: Internal index 0x01 reads back as follows: bits [7:0] hold the version (default 0x21), bits [23:16] hold the number of lines minus one (7), and all other bits are zero.
- R3: Bus offset 0x00 is select and offset 0x10 is the window. The low word of line n sits at index 0x10+2n and keeps only bit 16 (mask), bit 15 (level), bit 13 (active-low) and bits [7:0] (vector). The high word sits at 0x11+2n and keeps only bits [31:16]. A window read issued right after a window write returns the new value.
- R4: Any index other than 0x01 and 0x10..0x1F reads zero through the window, and window writes to it change nothing.
- R5: A line with bit 16 set sends no message.
- R6: With bit 13 set, a low input counts as asserted and a high input counts as idle.
- R7: An edge-triggered line sends exactly one message for each rising edge of its asserted state, however long it stays asserted.
- R8: A level-triggered line sends one message and then nothing more until an EOI arrives whose data equals its vector.
- R9: A write to offset 0x40 re-sends a message only if a level-triggered, unmasked line whose vector equals data bits [7:0] is still asserted. A non-matching vector, or a line that has been released, yields no message.
- R10: The message address is {high[31:24], high[23:16], 16'h0000}. The message data is {24'h0, vector}.
- R11: When several lines are pending, the lowest line number goes first. Only one message is outstanding at a time, and msg_req, msg_addr and msg_data stay stable until msg_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset: 0x00 select, 0x10 window, 0x40 EOI |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_in | input | 8 | Asynchronous interrupt lines |
| msg_req | output | 1 | Message pending on the write port |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data (vector) |
| msg_ack | input | 1 | Message accepted |

## Verification
The bench holds a level line asserted across a non-matching EOI and then a matching EOI. A design that compared the vector carelessly would either re-send too early or never re-arm. It holds an edge line high for many cycles; a design that treated the edge as a level would emit a stream of messages. It also unmasks an active-low line while that line is idle, to catch a polarity change that triggers a false edge. Finally, it fires two lines in the same cycle and delays the acknowledge, which exposes a wrong priority order and a message that changes or is dropped before it is accepted.

// File: rtl/irqr_pkg.sv
// Package: shared field layout and constants of the interrupt redirector.
// Assumes 32-bit register words and an 8-bit internal index space.
package irqr_pkg;
    localparam logic [6:0] OFF_SEL = 7'h00;
    localparam logic [6:0] OFF_WIN = 7'h10;
    localparam logic [6:0] OFF_EOI = 7'h40;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_TBL = 8'h10;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       pol_low;
        logic [7:0] vec;
    } lo_t;

    typedef struct packed {
        logic [7:0] id;
        logic [7:0] eid;
    } hi_t;

    localparam lo_t LO_RST = '{mask: 1'b1, level: 1'b0, pol_low: 1'b0, vec: 8'h00};
    localparam hi_t HI_RST = '{id: 8'h00, eid: 8'h00};
endpackage

// File: rtl/irqr_regfile.sv
// Register file: select/window access to the version word and the
// redirection table, plus decoding of EOI writes.
// Assumes single-cycle bus writes and combinational reads.
module irqr_regfile
    import irqr_pkg::*;
#(
    parameter int         NLINES  = 8,
    parameter logic [7:0] VERSION = 8'h21
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [6:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output lo_t  [NLINES-1:0]     lo_q,
    output hi_t  [NLINES-1:0]     hi_q,
    output logic                  eoi_stb,
    output logic [7:0]            eoi_vec
);
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;
    localparam logic [7:0] MAXIDX = 8'(NLINES - 1);

    logic [7:0]  sel_q;
    logic [7:0]  off;
    logic        entry_ok;
    logic [LW-1:0] line;
    logic        sel_wr, win_wr;
    logic [31:0] win_word;
    wire unused_wbits = ^{bus_wdata[14], bus_wdata[12:8]};

    // Decode the bus strobe into select, window and EOI actions.
    always_comb begin
        sel_wr   = bus_en & bus_we & (bus_addr == OFF_SEL);
        win_wr   = bus_en & bus_we & (bus_addr == OFF_WIN);
        eoi_stb  = bus_en & bus_we & (bus_addr == OFF_EOI);
        eoi_vec  = bus_wdata[7:0];
        off      = sel_q - IDX_TBL;
        entry_ok = (sel_q >= IDX_TBL) && (off < 8'(2 * NLINES));
        line     = off[LW:1];
    end

    // Hold the select index and the table; apply window writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
            for (int i = 0; i < NLINES; i++) begin
                lo_q[i] <= LO_RST;
                hi_q[i] <= HI_RST;
            end
        end else begin
            if (sel_wr) sel_q <= bus_wdata[7:0];
            if (win_wr && entry_ok) begin
                if (off[0]) begin
                    hi_q[line] <= '{id: bus_wdata[31:24], eid: bus_wdata[23:16]};
                end else begin
                    lo_q[line] <= '{mask: bus_wdata[16], level: bus_wdata[15],
                                    pol_low: bus_wdata[13], vec: bus_wdata[7:0]};
                end
            end
        end
    end

    // Form the word seen through the window for the current index.
    always_comb begin
        win_word = 32'h0;
        if (sel_q == IDX_VER) begin
            win_word = {8'h00, MAXIDX, 8'h00, VERSION};
        end else if (entry_ok) begin
            if (off[0]) win_word = {hi_q[line].id, hi_q[line].eid, 16'h0000};
            else        win_word = {15'h0, lo_q[line].mask, lo_q[line].level, 1'b0,
                                    lo_q[line].pol_low, 5'h00, lo_q[line].vec};
        end
    end

    // Drive read data for read strobes only.
    always_comb begin
        bus_rdata = 32'h0;
        if (bus_en && !bus_we) begin
            if (bus_addr == OFF_SEL)      bus_rdata = {24'h0, sel_q};
            else if (bus_addr == OFF_WIN) bus_rdata = win_word;
        end
    end

    // R4: a window write to an unimplemented index leaves the table alone.
    p_unimpl_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !entry_ok) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/irqr_line.sv
// One input line: two-flop synchronizer, polarity correction, edge or
// level detection, the pending flag and the level in-service flag.
// Assumes grant is only raised while pend_o is high.
module irqr_line
    import irqr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_raw,
    input  lo_t        cfg,
    input  logic       eoi_stb,
    input  logic [7:0] eoi_vec,
    input  logic       grant,
    output logic       pend_o
);
    logic s1_q, s2_q, prev_q, pend_q, insvc_q;
    logic act, rise, eoi_hit;

    // Derive the asserted state, its rising edge and a matching EOI.
    always_comb begin
        act     = s2_q ^ cfg.pol_low;
        rise    = act & ~prev_q;
        eoi_hit = eoi_stb & cfg.level & (eoi_vec == cfg.vec);
        pend_o  = pend_q & ~cfg.mask;
    end

    // Synchronize the raw input and remember the last asserted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= irq_raw;
            s2_q   <= s1_q;
            prev_q <= act;
        end
    end

    // Track the pending message for this line.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (cfg.mask)   pend_q <= 1'b0;
        else if (grant)      pend_q <= 1'b0;
        else if (cfg.level) begin
            if (act && !insvc_q) pend_q <= 1'b1;
            else if (!act)       pend_q <= 1'b0;
        end else if (rise)   pend_q <= 1'b1;
    end

    // Track the in-service state of a level-triggered line.
    always_ff @(posedge clk) begin
        if (!rst_n)          insvc_q <= 1'b0;
        else if (!cfg.level) insvc_q <= 1'b0;
        else if (grant)      insvc_q <= 1'b1;
        else if (eoi_hit)    insvc_q <= 1'b0;
    end

    // R5: a masked line holds no pending message on the next cycle.
    p_masked_no_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mask |=> !pend_q);
    // R8: an in-service level line queues nothing until its EOI.
    p_level_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && insvc_q && !eoi_hit) |=> !pend_q);
endmodule

// File: rtl/irqr_arb.sv
// Fixed-priority arbiter and output register for the message write port.
// Lowest line wins; one message is held until it is acknowledged.
module irqr_arb #(
    parameter int NLINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        pend,
    input  logic [NLINES-1:0][7:0]   vec,
    input  logic [NLINES-1:0][15:0]  dest,
    input  logic                     msg_ack,
    output logic [NLINES-1:0]        grant,
    output logic                     msg_req,
    output logic [31:0]              msg_addr,
    output logic [31:0]              msg_data
);
    logic [7:0]  g_vec;
    logic [15:0] g_dest;

    // Pick the lowest pending line while the port is free.
    always_comb begin
        grant  = '0;
        g_vec  = 8'h00;
        g_dest = 16'h0000;
        if (!msg_req) begin
            for (int i = NLINES - 1; i >= 0; i--) begin
                if (pend[i]) begin
                    grant  = '0;
                    grant[i] = 1'b1;
                    g_vec  = vec[i];
                    g_dest = dest[i];
                end
            end
        end
    end

    // Load a granted message and hold it until the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_req  <= 1'b0;
            msg_addr <= 32'h0;
            msg_data <= 32'h0;
        end else if (msg_req && msg_ack) begin
            msg_req  <= 1'b0;
        end else if (|grant) begin
            msg_req  <= 1'b1;
            msg_addr <= {g_dest, 16'h0000};
            msg_data <= {24'h0, g_vec};
        end
    end

    // R11: an unacknowledged message stays unchanged.
    p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));
    // R11: at most one line is granted per cycle.
    p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R5: a message only starts when some line was pending.
    p_req_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |-> $past(|pend));
endmodule

// File: rtl/irq_msg_redirect.sv
// Top: converts NLINES interrupt lines into posted write messages.
// Register access goes through select/window; EOI re-arms level lines.
module irq_msg_redirect
    import irqr_pkg::*;
#(
    parameter int         NLINES  = 8,
    parameter logic [7:0] VERSION = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] irq_in,
    output logic              msg_req,
    output logic [31:0]       msg_addr,
    output logic [31:0]       msg_data,
    input  logic              msg_ack
);
    lo_t  [NLINES-1:0]       lo_q;
    hi_t  [NLINES-1:0]       hi_q;
    logic                    eoi_stb;
    logic [7:0]              eoi_vec;
    logic [NLINES-1:0]       pend, grant;
    logic [NLINES-1:0][7:0]  vec;
    logic [NLINES-1:0][15:0] dest;

    irqr_regfile #(.NLINES(NLINES), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lo_q(lo_q), .hi_q(hi_q), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        assign vec[g]  = lo_q[g].vec;
        assign dest[g] = {hi_q[g].id, hi_q[g].eid};
        irqr_line u_line (
            .clk(clk), .rst_n(rst_n), .irq_raw(irq_in[g]), .cfg(lo_q[g]),
            .eoi_stb(eoi_stb), .eoi_vec(eoi_vec), .grant(grant[g]),
            .pend_o(pend[g])
        );
    end

    irqr_arb #(.NLINES(NLINES)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .vec(vec), .dest(dest),
        .msg_ack(msg_ack), .grant(grant), .msg_req(msg_req),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );
endmodule

// File: tb/irq_msg_redirect_test.sv
// Directed bench for irq_msg_redirect: one task per scenario.
module irq_msg_redirect_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_in = '0;
    logic        msg_req, msg_ack = 1'b0;
    logic [31:0] msg_addr, msg_data;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_msg_redirect uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .msg_req(msg_req), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_ack(msg_ack)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic win_write(logic [7:0] idx, logic [31:0] d);
        bus_write(7'h00, {24'h0, idx});
        bus_write(7'h10, d);
    endtask

    task automatic win_read(logic [7:0] idx, output logic [31:0] d);
        bus_write(7'h00, {24'h0, idx});
        bus_read(7'h10, d);
    endtask

    // Wait for a message, hold it hold cycles checking stability, then acknowledge.
    task automatic take_msg(string req, logic [31:0] ea, logic [31:0] ed, int hold);
        int t = 0;
        @(negedge clk);
        while (!msg_req && t < 30) begin @(negedge clk); t++; end
        check({req, " message present"}, {31'h0, msg_req}, 32'h1);
        check({req, " address"}, msg_addr, ea);
        check({req, " data"}, msg_data, ed);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R11 held until ack", {msg_req, msg_data[30:0]}, {1'b1, ed[30:0]});
        end
        msg_ack = 1;
        @(negedge clk);
        msg_ack = 0;
    endtask

    task automatic no_msg(string req, int cycles);
        logic seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (msg_req) begin
                seen = 1; msg_ack = 1;
                @(negedge clk);
                msg_ack = 0;
            end
        end
        check({req, " no message"}, {31'h0, seen}, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(7'h00, d);
        check("R1 select reset", d, 32'h0);
        check("R1 msg_req reset", {31'h0, msg_req}, 32'h0);
        win_read(8'h10, d); check("R1 line0 low reset", d, 32'h0001_0000);
        win_read(8'h1E, d); check("R1 line7 low reset", d, 32'h0001_0000);
        win_read(8'h1F, d); check("R1 line7 high reset", d, 32'h0);
    endtask

    task automatic t_version;
        logic [31:0] d;
        win_read(8'h01, d);
        check("R2 version word", d, 32'h0007_0021);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        win_write(8'h12, 32'hFFFF_FFFF);
        bus_read(7'h10, d); check("R3 low word kept bits", d, 32'h0001_A0FF);
        win_write(8'h13, 32'hFFFF_FFFF);
        bus_read(7'h10, d); check("R3 high word kept bits", d, 32'hFFFF_0000);
        win_read(8'h14, d); check("R3 neighbour untouched", d, 32'h0001_0000);
        win_write(8'h12, 32'h0001_0000);
        win_write(8'h13, 32'h0);
    endtask

    task automatic t_unimpl;
        logic [31:0] d;
        win_write(8'h02, 32'hDEAD_BEEF);
        bus_read(7'h10, d); check("R4 index 0x02 reads zero", d, 32'h0);
        win_write(8'h20, 32'hFFFF_FFFF);
        bus_read(7'h10, d); check("R4 index 0x20 reads zero", d, 32'h0);
        win_write(8'h0F, 32'hFFFF_FFFF);
        bus_read(7'h10, d); check("R4 index 0x0F reads zero", d, 32'h0);
        win_read(8'h1E, d); check("R4 table unchanged", d, 32'h0001_0000);
        win_read(8'h11, d); check("R4 high unchanged", d, 32'h0);
    endtask

    task automatic t_mask;
        irq_in[0] = 1;
        no_msg("R5 masked line", 12);
        irq_in[0] = 0;
    endtask

    task automatic t_edge;
        win_write(8'h15, 32'hABCD_0000);
        win_write(8'h14, 32'h0000_0042);
        irq_in[2] = 1;
        take_msg("R7 R10 edge", 32'hABCD_0000, 32'h42, 0);
        no_msg("R7 held high", 12);
        irq_in[2] = 0;
        no_msg("R7 falling edge", 8);
        irq_in[2] = 1;
        take_msg("R7 second edge", 32'hABCD_0000, 32'h42, 0);
        irq_in[2] = 0;
        win_write(8'h14, 32'h0001_0000);
    endtask

    task automatic t_level;
        win_write(8'h17, 32'h1122_0000);
        win_write(8'h16, 32'h0000_8055);
        irq_in[3] = 1;
        take_msg("R8 level first", 32'h1122_0000, 32'h55, 0);
        no_msg("R8 in service", 12);
        bus_write(7'h40, 32'h56);
        no_msg("R9 wrong vector EOI", 10);
        bus_write(7'h40, 32'h55);
        take_msg("R9 matching EOI resend", 32'h1122_0000, 32'h55, 0);
        irq_in[3] = 0;
        repeat (4) @(negedge clk);
        bus_write(7'h40, 32'h55);
        no_msg("R9 EOI after release", 10);
        win_write(8'h16, 32'h0001_0000);
    endtask

    task automatic t_polarity;
        irq_in[4] = 1;
        repeat (4) @(negedge clk);
        win_write(8'h18, 32'h0000_2066);
        no_msg("R6 high input idle", 8);
        irq_in[4] = 0;
        take_msg("R6 low input asserts", 32'h0, 32'h66, 0);
        irq_in[4] = 1;
        win_write(8'h18, 32'h0001_0000);
    endtask

    task automatic t_priority;
        win_write(8'h1A, 32'h0000_0065);
        win_write(8'h1C, 32'h0000_0076);
        @(negedge clk);
        irq_in[6] = 1; irq_in[5] = 1;
        take_msg("R11 lowest line first", 32'h0, 32'h65, 3);
        take_msg("R11 next line", 32'h0, 32'h76, 2);
        no_msg("R11 nothing further", 10);
        irq_in[6] = 0; irq_in[5] = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_version;
        t_regs;
        t_unimpl;
        t_mask;
        t_edge;
        t_level;
        t_polarity;
        t_priority;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule